// File: doc/BRIEF.md
# Watchdog and Stop-Recovery Reset Controller

This block supervises the core reset of a small microcontroller. It combines a watchdog counter, which the core arms and re-arms with a restart strobe, with a controller that handles the low-power stop state. The controller takes the device into stop when the core reports it, releases it on a qualified wake event, and decides which register bits survive each kind of reset. Every reset it raises holds the core in reset for a fixed delay. The one exception is a stop recovery with the delay bypassed, which gives a single-cycle reset pulse.

Two registers are written through a small port and are visible on the outputs. The watchdog mode register holds a five-bit timeout select, split across bits 6:4 and 1:0, and a keep-counting-in-stop flag in bit 3. The stop control register holds the delay-select bit 5, a second preserved bit 6, five general bits in 4:0, and a read-only reset-cause bit 7. The reset-cause bit tells a stop recovery apart from a power-on or watchdog reset.

A watchdog timeout always produces a full-delay reset. The mode register is kept when the timeout happens during stop and returns to its default otherwise. After any reset the watchdog stays idle until the core restarts it.

Top module: `wdt_stop_reset_ctrl`

## Requirements
- R1: While `por_rst_n` is low, and for exactly 64 clock edges after it goes high, `core_rst_n` is 0. The registers reset to mode 0x00 and stop control 0x20.
- R2: The watchdog counts only after a `wd_restart` seen while the core runs. Each restart reloads the count to zero. With select s = {mode[6:4], mode[1:0]}, a timeout resets the core 2^(4+s) edges after the last restart (exponent capped at 16).
- R3: When mode bit 3 is 1, the watchdog keeps counting in stop. A timeout there resets the core with the full 64-cycle delay, keeps the mode register and restores stop control to 0x20.
- R4: A timeout while running returns the mode register to 0x00 and stop control to 0x20.
- R5: After any reset the watchdog is disabled. No further timeout occurs until a new restart.
- R6: Stop control bit 7 reads 1 after a stop recovery and 0 after power-on or watchdog reset. Writes do not change it.
- R7: A stop recovery keeps stop control bits 6:5 and the mode register, clears stop control bits 4:0, and sets bit 7.
- R8: With stop control bit 5 = 1, a single wake cycle in stop is accepted, and the core is held in reset for 64 edges.
- R9: With stop control bit 5 = 0, wake must be high for 10 consecutive edges in stop. A shorter burst is ignored. On acceptance, `core_rst_n` is 0 for one cycle only.
- R10: Mode writes (`reg_sel`=0) are taken only while the watchdog is disabled. Mode bits 7 and 2 always read 0.
- R11: When mode bit 3 is 0, the watchdog count is frozen during stop, and no timeout occurs while stopped.
- R12: A restart on the same edge as the terminal count reloads the watchdog. No reset occurs.
- R13: A watchdog timeout and an accepted wake on the same edge in stop resolve as a watchdog reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_rst_n | input | 1 | Power-on / brownout reset, active low, synchronous |
| wd_restart | input | 1 | Watchdog restart strobe from the core |
| stop_enter | input | 1 | Strobe: core has entered stop |
| wake_src | input | 1 | Stop-recovery wake source level |
| reg_wr | input | 1 | Register write enable |
| reg_sel | input | 1 | 0 = watchdog mode register, 1 = stop control register |
| reg_wdata | input | 8 | Write data |
| core_rst_n | output | 1 | Core reset, active low |
| rst_from_stop | output | 1 | Reset cause: 1 = last reset was a stop recovery |
| wdmode_q | output | 8 | Watchdog mode register |
| stopctl_q | output | 8 | Stop control register |

## Verification
Two pairs of functions can fall on the same edge. A core restart can land on the watchdog's terminal count, and a watchdog timeout can coincide with an accepted wake in stop. The bench counts the exact cycles from a restart, then drives the restart or the wake so that it is present at the edge where the count expires. For the restart, it judges by the length of the next timeout interval: a full interval means the restart won. For the wake, it judges by the cause bit and the register contents that follow, which must show a watchdog reset.

// File: rtl/wsr_pkg.sv
// Shared types and constants for the watchdog / stop-recovery reset controller.
// Assumes 8-bit control registers with the field positions listed in the brief.
package wsr_pkg;
    typedef enum logic [1:0] {S_DLY = 2'd0, S_RUN = 2'd1, S_STOP = 2'd2} rst_state_t;

    localparam logic [7:0] WDM_DEF   = 8'h00;  // shortest timeout, no counting in stop
    localparam logic [7:0] WDM_WMASK = 8'h7B;  // bits 7 and 2 unused
    localparam logic [7:0] SMR_DEF   = 8'h20;  // delay timer in use
    localparam logic [7:0] SMR_KEEP  = 8'h60;  // bits kept across stop recovery
endpackage

// File: rtl/wsr_wdog.sv
// Watchdog counter. Idle until restarted; counts while cnt_allow is high;
// raises timeout on the edge where the count sits at the selected limit.
// Assumes halt is high while the core is held in reset.
module wsr_wdog #(
    parameter int CNT_W    = 16,
    parameter int TAP_BASE = 4,
    parameter int SEL_W    = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             cnt_allow,
    input  logic             halt,
    input  logic [SEL_W-1:0] sel,
    output logic             en_q,
    output logic             timeout
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] limit;
    logic [CNT_W:0]   span;

    // Decode the timeout select into a terminal count (power of two minus one).
    always_comb begin
        int e;
        e = TAP_BASE + int'(sel);
        if (e > CNT_W) e = CNT_W;
        span  = ({{CNT_W{1'b0}}, 1'b1} << e) - {{CNT_W{1'b0}}, 1'b1};
        limit = span[CNT_W-1:0];
    end

    // Terminal count reached on a counting edge, unless a restart wins.
    assign timeout = en_q && cnt_allow && !restart && !halt && (cnt_q == limit);

    // Counter and enable state.
    always_ff @(posedge clk) begin
        if (!rst_n || halt) begin
            en_q  <= 1'b0;
            cnt_q <= '0;
        end else if (restart) begin
            en_q  <= 1'b1;
            cnt_q <= '0;
        end else if (timeout) begin
            en_q  <= 1'b0;
            cnt_q <= '0;
        end else if (en_q && cnt_allow) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/wsr_wake_qual.sv
// Wake qualifier. In stop, accepts a wake either at once or after it has been
// high for WAKE_MIN consecutive edges. Assumes armed is high only in stop.
module wsr_wake_qual #(
    parameter int WAKE_MIN = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic armed,
    input  logic wake,
    input  logic need_long,
    output logic accept
);
    localparam int WK_W = $clog2(WAKE_MIN + 1);
    localparam logic [WK_W-1:0] WK_LAST = WK_W'(WAKE_MIN - 1);

    logic [WK_W-1:0] run_q;

    // Accept when wake is high and, if required, has been high long enough.
    assign accept = armed && wake && (!need_long || (run_q == WK_LAST));

    // Count consecutive high wake cycles while armed.
    always_ff @(posedge clk) begin
        if (!rst_n || !armed || !wake) run_q <= '0;
        else if (run_q != WK_LAST)     run_q <= run_q + 1'b1;
    end
endmodule

// File: rtl/wsr_rst_seq.sv
// Reset sequencer. Holds the core in reset for a delay, runs, enters stop,
// and leaves stop or run on watchdog timeout or accepted wake.
// Assumes wd_to has priority over wake_ok.
module wsr_rst_seq
    import wsr_pkg::*;
#(
    parameter int DLY_LEN = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wd_to,
    input  logic       stop_req,
    input  logic       wake_ok,
    input  logic       long_dly,
    output rst_state_t state_q
);
    localparam int DLY_W = $clog2(DLY_LEN);
    localparam logic [DLY_W-1:0] DLY_TOP = DLY_W'(DLY_LEN - 1);

    logic [DLY_W-1:0] dly_q;

    // State transitions and reset delay countdown.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_DLY;
            dly_q   <= DLY_TOP;
        end else begin
            case (state_q)
                S_DLY: begin
                    if (dly_q == '0) state_q <= S_RUN;
                    else             dly_q   <= dly_q - 1'b1;
                end
                S_RUN: begin
                    if (wd_to) begin
                        state_q <= S_DLY;
                        dly_q   <= DLY_TOP;
                    end else if (stop_req) begin
                        state_q <= S_STOP;
                    end
                end
                S_STOP: begin
                    if (wd_to) begin
                        state_q <= S_DLY;
                        dly_q   <= DLY_TOP;
                    end else if (wake_ok) begin
                        state_q <= S_DLY;
                        dly_q   <= long_dly ? DLY_TOP : '0;
                    end
                end
                default: state_q <= S_DLY;
            endcase
        end
    end
endmodule

// File: rtl/wdt_stop_reset_ctrl.sv
// Watchdog and stop-recovery reset controller top. Owns the mode and stop
// control registers and applies the per-reset-type retention rules.
// Assumes a synchronous active-low power-on reset.
module wdt_stop_reset_ctrl
    import wsr_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int TAP_BASE = 4,
    parameter int DLY_LEN  = 64,
    parameter int WAKE_MIN = 10
) (
    input  logic       clk,
    input  logic       por_rst_n,
    input  logic       wd_restart,
    input  logic       stop_enter,
    input  logic       wake_src,
    input  logic       reg_wr,
    input  logic       reg_sel,
    input  logic [7:0] reg_wdata,
    output logic       core_rst_n,
    output logic       rst_from_stop,
    output logic [7:0] wdmode_q,
    output logic [7:0] stopctl_q
);
    localparam int SEL_W = 5;

    rst_state_t state_q;
    logic       wd_en, wd_to, wake_ok, stop_wake;
    logic       run, stopped;

    assign run       = (state_q == S_RUN);
    assign stopped   = (state_q == S_STOP);
    assign stop_wake = stopped && wake_ok && !wd_to;

    wsr_wdog #(.CNT_W(CNT_W), .TAP_BASE(TAP_BASE), .SEL_W(SEL_W)) u_wdog (
        .clk      (clk),
        .rst_n    (por_rst_n),
        .restart  (wd_restart && run),
        .cnt_allow(run || (stopped && wdmode_q[3])),
        .halt     (state_q == S_DLY),
        .sel      ({wdmode_q[6:4], wdmode_q[1:0]}),
        .en_q     (wd_en),
        .timeout  (wd_to)
    );

    wsr_wake_qual #(.WAKE_MIN(WAKE_MIN)) u_wake (
        .clk      (clk),
        .rst_n    (por_rst_n),
        .armed    (stopped),
        .wake     (wake_src),
        .need_long(!stopctl_q[5]),
        .accept   (wake_ok)
    );

    wsr_rst_seq #(.DLY_LEN(DLY_LEN)) u_seq (
        .clk     (clk),
        .rst_n   (por_rst_n),
        .wd_to   (wd_to),
        .stop_req(stop_enter),
        .wake_ok (wake_ok),
        .long_dly(stopctl_q[5]),
        .state_q (state_q)
    );

    // Register updates with per-reset-type retention and the write lock.
    always_ff @(posedge clk) begin
        if (!por_rst_n) begin
            wdmode_q  <= WDM_DEF;
            stopctl_q <= SMR_DEF;
        end else if (wd_to) begin
            stopctl_q <= SMR_DEF;
            if (run) wdmode_q <= WDM_DEF;
        end else if (stop_wake) begin
            stopctl_q <= (stopctl_q & SMR_KEEP) | (SMR_DEF & ~SMR_KEEP & 8'h7F) | 8'h80;
        end else if (reg_wr && run) begin
            if (!reg_sel && !wd_en) wdmode_q <= reg_wdata & WDM_WMASK;
            if (reg_sel)            stopctl_q <= {stopctl_q[7], reg_wdata[6:0]};
        end
    end

    assign core_rst_n    = (state_q != S_DLY);
    assign rst_from_stop = stopctl_q[7];
endmodule

// File: rtl/wsr_checker.sv
// Assertion checker for the reset controller, attached by bind.
module wsr_checker
    import wsr_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       core_rst_n,
    input logic       wd_en,
    input logic       wd_to,
    input logic       stop_wake,
    input rst_state_t state_q,
    input logic [7:0] wdmode_q,
    input logic [7:0] stopctl_q
);
    AST_WD_IDLE_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        (!core_rst_n && $past(!core_rst_n)) |-> !wd_en);  // R5
    AST_MODE_KEPT_STOP_TO: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_STOP && wd_to) |=> $stable(wdmode_q));  // R3
    AST_MODE_DEF_RUN_TO: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_RUN && wd_to) |=> (wdmode_q == WDM_DEF));  // R4
    AST_CAUSE_SET_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        stop_wake |=> stopctl_q[7]);  // R6
    AST_CAUSE_CLR_WD: assert property (@(posedge clk) disable iff (!rst_n)
        wd_to |=> !stopctl_q[7]);  // R6
    AST_MODE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (wd_en && !wd_to) |=> $stable(wdmode_q));  // R10
    AST_BYPASS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_wake && !stopctl_q[5]) |=> !core_rst_n ##1 core_rst_n);  // R9
endmodule

bind wdt_stop_reset_ctrl wsr_checker u_chk (
    .clk       (clk),
    .rst_n     (por_rst_n),
    .core_rst_n(core_rst_n),
    .wd_en     (wd_en),
    .wd_to     (wd_to),
    .stop_wake (stop_wake),
    .state_q   (state_q),
    .wdmode_q  (wdmode_q),
    .stopctl_q (stopctl_q)
);

// File: tb/wdt_stop_reset_ctrl_bench.sv
module wdt_stop_reset_ctrl_bench;
    logic       clk = 1'b0;
    logic       por_rst_n = 1'b0;
    logic       wd_restart = 1'b0, stop_enter = 1'b0, wake_src = 1'b0;
    logic       reg_wr = 1'b0, reg_sel = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic       core_rst_n, rst_from_stop;
    logic [7:0] wdmode_q, stopctl_q;
    int         n_vec = 0, n_bad = 0;

    always #10 clk = ~clk;

    wdt_stop_reset_ctrl u_wdt_stop_reset_ctrl (
        .clk(clk), .por_rst_n(por_rst_n), .wd_restart(wd_restart),
        .stop_enter(stop_enter), .wake_src(wake_src), .reg_wr(reg_wr),
        .reg_sel(reg_sel), .reg_wdata(reg_wdata), .core_rst_n(core_rst_n),
        .rst_from_stop(rst_from_stop), .wdmode_q(wdmode_q), .stopctl_q(stopctl_q)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // Steps taken until core_rst_n leaves level lvl.
    task automatic hold_len(input logic lvl, output int n);
        n = 0;
        while (core_rst_n === lvl && n < 70000) begin
            step(1);
            n++;
        end
    endtask

    task automatic por();
        int n;
        por_rst_n = 1'b0;
        step(3);
        chk("R1 reset core", int'(core_rst_n), 0);
        chk("R1 reset mode", int'(wdmode_q), 8'h00);
        chk("R1 reset stop", int'(stopctl_q), 8'h20);
        por_rst_n = 1'b1;
        hold_len(1'b0, n);
        chk("R1 delay", n, 64);
    endtask

    task automatic wr(input logic sel, input logic [7:0] d);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
        step(1);
        reg_wr = 1'b0;
    endtask

    task automatic kick();
        wd_restart = 1'b1;
        step(1);
        wd_restart = 1'b0;
    endtask

    task automatic pulse_stop();
        stop_enter = 1'b1;
        step(1);
        stop_enter = 1'b0;
    endtask

    initial begin
        int n;
        int lows;
        @(negedge clk);

        // R2 / R4: sweep timeout selects 0..7 while running
        for (int s = 0; s < 8; s++) begin
            por();
            wr(1'b0, 8'(((s >> 2) & 7) << 4 | (s & 3)));
            kick();
            hold_len(1'b1, n);
            chk("R2 timeout length", n, 1 << (4 + s));
            chk("R4 mode default", int'(wdmode_q), 8'h00);
            chk("R4 stop default", int'(stopctl_q), 8'h20);
            chk("R6 cause after wdog", int'(rst_from_stop), 0);
            hold_len(1'b0, n);
            chk("R4 wdog delay", n, 64);
        end

        // R5: no further timeout without a restart
        lows = 0;
        for (int i = 0; i < 200; i++) begin
            step(1);
            if (!core_rst_n) lows++;
        end
        chk("R5 idle after reset", lows, 0);

        // R10: mask, then write lock once counting
        por();
        wr(1'b0, 8'hFF);
        chk("R10 unused bits", int'(wdmode_q), 8'h7B);
        wr(1'b0, 8'h01);
        kick();
        wr(1'b0, 8'h7B);
        chk("R10 locked", int'(wdmode_q), 8'h01);
        hold_len(1'b1, n);
        chk("R10 timeout kept sel1", n, 31);

        // R6: cause bit not writable after power-on
        por();
        wr(1'b1, 8'hFF);
        chk("R6 write bit7 ignored", int'(stopctl_q), 8'h7F);

        // R11 / R7 / R8: frozen in stop, single-cycle wake, retention
        por();
        wr(1'b0, 8'h02);
        wr(1'b1, 8'h7F);
        kick();
        step(4);
        pulse_stop();
        lows = 0;
        for (int i = 0; i < 200; i++) begin
            step(1);
            if (!core_rst_n) lows++;
        end
        chk("R11 frozen in stop", lows, 0);
        wake_src = 1'b1;
        step(1);
        wake_src = 1'b0;
        chk("R8 wake accepted", int'(core_rst_n), 0);
        hold_len(1'b0, n);
        chk("R8 delay", n, 64);
        chk("R7 stop retained", int'(stopctl_q), 8'hE0);
        chk("R7 mode retained", int'(wdmode_q), 8'h02);
        chk("R6 cause after wake", int'(rst_from_stop), 1);
        wr(1'b1, 8'h00);
        chk("R6 bit7 survives write", int'(stopctl_q), 8'h80);

        // R9: bypassed delay, 10-cycle wake qualification
        por();
        wr(1'b1, 8'h00);
        pulse_stop();
        wake_src = 1'b1;
        step(9);
        wake_src = 1'b0;
        step(1);
        chk("R9 short burst ignored", int'(core_rst_n), 1);
        wake_src = 1'b1;
        step(9);
        chk("R9 not yet at 9", int'(core_rst_n), 1);
        step(1);
        chk("R9 accepted at 10", int'(core_rst_n), 0);
        step(1);
        chk("R9 one-cycle pulse", int'(core_rst_n), 1);
        wake_src = 1'b0;
        chk("R9 stop after wake", int'(stopctl_q), 8'h80);

        // R3: counting continues in stop, mode kept
        por();
        wr(1'b0, 8'h08);
        kick();
        stop_enter = 1'b1;
        step(1);
        stop_enter = 1'b0;
        hold_len(1'b1, n);
        chk("R3 timeout in stop", n + 1, 16);
        chk("R3 mode kept", int'(wdmode_q), 8'h08);
        chk("R3 stop default", int'(stopctl_q), 8'h20);
        hold_len(1'b0, n);
        chk("R3 delay", n, 64);

        // R12: restart on the terminal-count edge
        por();
        kick();
        lows = 0;
        for (int i = 0; i < 15; i++) begin
            step(1);
            if (!core_rst_n) lows++;
        end
        kick();
        chk("R12 no reset on tie", lows + (core_rst_n ? 0 : 1), 0);
        hold_len(1'b1, n);
        chk("R12 full new interval", n, 16);

        // R13: timeout and wake on the same edge in stop
        por();
        wr(1'b0, 8'h08);
        kick();
        pulse_stop();
        step(14);
        wake_src = 1'b1;
        step(1);
        wake_src = 1'b0;
        chk("R13 reset taken", int'(core_rst_n), 0);
        chk("R13 cause is wdog", int'(rst_from_stop), 0);
        chk("R13 stop default", int'(stopctl_q), 8'h20);
        chk("R13 mode kept", int'(wdmode_q), 8'h08);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #(20 * 150000);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule